// File: doc/BRIEF.md
# Receive Offset Calibration Controller

This block is a digital servo that removes the self-generated DC offset of a receive amplifier's input stage. It does this by trimming a signed calibration DAC code while it reads the converter's own output. During a calibration it drives two controls. One shorts the amplifier input. The other pins every gain stage at a fixed high gain. With those held, whatever the converter reads is offset produced by the amplifier itself. The block makes no attempt to cancel offset that enters from outside the device.

A calibration begins by itself as soon as reset is released. A one-cycle command strobe from the register interface starts another one. Each measurement follows the same sequence:

1. Wait through a settling interval.
2. Average a block of samples.
3. Compare the result against a tolerance window.

If the result lies inside the window, the block stops and keeps the code. If it lies outside, the code moves one step against the sign of the offset and the sequence repeats. If the iteration budget runs out, the block keeps the best code it found and flags a failure.

Top module: `rx_offset_cal`

## Requirements
- R1: From reset, `busy`, `force_short` and `force_gain` are high, `cal_dac` is 0 and `done` is low. The first calibration runs without any command.
- R2: A `cal_start` pulse while `busy` is low starts a new calibration, and `busy` rises on the next cycle. The code restarts from 0 and is not continued from the previous result.
- R3: `force_short` and `force_gain` equal `busy` in every cycle.
- R4: `adc_data` is a two's-complement 12-bit sample. The offset estimate is the sum of 64 consecutive samples taken while `adc_valid` is high, shifted arithmetically right by 6. Samples with `adc_valid` low are skipped.
- R5: When the estimate lies in the range -32 to +32 inclusive, the calibration ends, `cal_dac` keeps its current value and `fail` is low.
- R6: When the estimate lies outside that range, the code changes by exactly one: down for a positive estimate, up for a negative one. `cal_dac` is two's complement.
- R7: Each measurement first waits for 16 valid samples and then averages. With `adc_valid` held high, one measurement therefore takes 16 + 64 + 1 = 81 cycles, and `busy` stays high for 81 cycles per measurement.
- R8: After MAX_ITER measurements without success, the calibration ends with `fail` high. `cal_dac` then holds the code whose estimate had the smallest magnitude, and the earliest such code wins a tie.
- R9: `done` is high for exactly one cycle, which is the first cycle in which `busy` is low after a calibration.
- R10: A `cal_start` pulse while `busy` is high has no effect, and the calibration length is unchanged.
- R11: While `busy` is low, `cal_dac` stays constant whatever `adc_data` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset; release starts a calibration |
| cal_start | input | 1 | One-cycle calibration request from the register interface |
| adc_valid | input | 1 | Qualifies `adc_data` |
| adc_data | input | SAMPLE_W | Signed converter sample |
| cal_dac | output | DAC_W | Signed calibration DAC code |
| force_short | output | 1 | Shorts the amplifier input stage |
| force_gain | output | 1 | Overrides user gain with the fixed high gain |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | One-cycle end-of-calibration pulse |
| fail | output | 1 | Last calibration exhausted its budget |

## Verification
The bench builds the block with MAX_ITER set to 40 and keeps the defaults for everything else: 12-bit samples, a 64-sample average, a 16-sample settle, a ±32 window and an 8-bit code. The small budget brings the exhaustion path into reach within a few thousand cycles, and the full 81-cycle measurement timing stays intact. An arithmetic model of the amplifier then gives a closed-form step count, final code and busy length for each offset in the sweep. The sweep includes the window edges at ±32 and ±33, both signs, a different slope, alternating ±50 dither that only the average removes, gapped sample valids, and offsets too large to correct within the budget.

// File: rtl/rxcal_pkg.sv
package rxcal_pkg;

  typedef enum logic [1:0] {
    CAL_IDLE   = 2'd0,
    CAL_SETTLE = 2'd1,
    CAL_ACCUM  = 2'd2,
    CAL_EVAL   = 2'd3
  } cal_state_e;

  // Averaged offset: arithmetic shift of the block sum.
  function automatic int est_from_sum(input int sum, input int shift);
    return sum >>> shift;
  endfunction

  // Acceptance window, symmetric and inclusive.
  function automatic bit in_window(input int est, input int tol);
    return (est <= tol) && (est >= -tol);
  endfunction

  function automatic int mag_of(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // One servo step against the sign of the estimate, clamped to the code range.
  function automatic int next_code(input int code, input int est, input int lo, input int hi);
    if (est > 0) return (code > lo) ? code - 1 : code;
    if (est < 0) return (code < hi) ? code + 1 : code;
    return code;
  endfunction

endpackage

// File: rtl/rxcal_seq.sv
module rxcal_seq #(
  parameter int SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_start,
  input  logic adc_valid,
  input  logic acc_last,
  input  logic hit,
  input  logic exhausted,
  output logic start_evt,
  output logic eval_evt,
  output logic acc_clear,
  output logic acc_add,
  output logic busy,
  output logic done
);
  import rxcal_pkg::*;

  localparam int SET_W = $clog2(SETTLE_CYC + 1);

  cal_state_e state_q, state_d;
  logic [SET_W-1:0] settle_q;
  logic settle_end, finish_evt;

  assign start_evt  = (state_q == CAL_IDLE) && cal_start;
  assign eval_evt   = (state_q == CAL_EVAL);
  assign acc_clear  = (state_q == CAL_SETTLE);
  assign acc_add    = (state_q == CAL_ACCUM) && adc_valid;
  assign settle_end = (state_q == CAL_SETTLE) && adc_valid &&
                      (settle_q == SET_W'(SETTLE_CYC - 1));
  assign finish_evt = eval_evt && (hit || exhausted);
  assign busy       = (state_q != CAL_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CAL_IDLE:   if (cal_start) state_d = CAL_SETTLE;
      CAL_SETTLE: if (settle_end) state_d = CAL_ACCUM;
      CAL_ACCUM:  if (acc_last) state_d = CAL_EVAL;
      CAL_EVAL:   state_d = (hit || exhausted) ? CAL_IDLE : CAL_SETTLE;
      default:    state_d = CAL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= CAL_SETTLE;   // calibration begins on reset release
      settle_q <= '0;
      done     <= 1'b0;
    end else begin
      state_q  <= state_d;
      done     <= finish_evt;
      if (state_q != CAL_SETTLE) settle_q <= '0;
      else if (adc_valid)        settle_q <= settle_q + SET_W'(1);
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle");
  p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))) else $error("done not at busy fall");
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cal_start) |=> busy) else $error("request not taken");
  p_settle_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CAL_ACCUM && $past(state_q) == CAL_SETTLE) |->
      ($past(settle_q) == SET_W'(SETTLE_CYC - 1))) else $error("short settle");

endmodule

// File: rtl/rxcal_avg.sv
module rxcal_avg #(
  parameter int SAMPLE_W = 12,
  parameter int AVG_LOG2 = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       add,
  input  logic signed [SAMPLE_W-1:0] sample,
  output logic signed [SAMPLE_W-1:0] est,
  output logic                       last
);
  import rxcal_pkg::*;

  localparam int SUM_W = SAMPLE_W + AVG_LOG2;

  logic signed [SUM_W-1:0] sum_q;
  logic [AVG_LOG2-1:0]     cnt_q;

  assign last = add && (&cnt_q);
  assign est  = SAMPLE_W'(est_from_sum(int'(sum_q), AVG_LOG2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      cnt_q <= '0;
    end else if (clear) begin
      sum_q <= '0;
      cnt_q <= '0;
    end else if (add) begin
      sum_q <= sum_q + {{AVG_LOG2{sample[SAMPLE_W-1]}}, sample};
      cnt_q <= cnt_q + AVG_LOG2'(1);
    end
  end

  p_no_add_in_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> !add) else $error("accumulate during settle");

endmodule

// File: rtl/rxcal_servo.sv
module rxcal_servo #(
  parameter int SAMPLE_W = 12,
  parameter int DAC_W    = 8,
  parameter int TOL      = 32,
  parameter int MAX_ITER = 256
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_evt,
  input  logic                       eval_evt,
  input  logic signed [SAMPLE_W-1:0] est,
  output logic signed [DAC_W-1:0]    dac,
  output logic                       hit,
  output logic                       exhausted,
  output logic                       fail
);
  import rxcal_pkg::*;

  localparam int CNT_W   = (MAX_ITER > 1) ? $clog2(MAX_ITER) : 1;
  localparam int CODE_LO = -(2 ** (DAC_W - 1));
  localparam int CODE_HI = (2 ** (DAC_W - 1)) - 1;

  logic signed [DAC_W-1:0] dac_q, best_code_q, step_code;
  logic [SAMPLE_W-1:0]     best_mag_q, cur_mag;
  logic [CNT_W-1:0]        cnt_q;
  logic                    fail_q, better;
  int                      est_i;

  assign est_i     = int'(est);
  assign cur_mag   = SAMPLE_W'(mag_of(est_i));
  assign better    = cur_mag < best_mag_q;
  assign hit       = in_window(est_i, TOL);
  assign exhausted = (cnt_q == CNT_W'(MAX_ITER - 1));
  assign step_code = DAC_W'(next_code(int'(dac_q), est_i, CODE_LO, CODE_HI));
  assign dac       = dac_q;
  assign fail      = fail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_q       <= '0;
      best_code_q <= '0;
      best_mag_q  <= '1;
      cnt_q       <= '0;
      fail_q      <= 1'b0;
    end else if (start_evt) begin
      dac_q       <= '0;
      best_code_q <= '0;
      best_mag_q  <= '1;
      cnt_q       <= '0;
      fail_q      <= 1'b0;
    end else if (eval_evt) begin
      if (hit) begin
        fail_q <= 1'b0;
      end else if (exhausted) begin
        dac_q  <= better ? dac_q : best_code_q;
        fail_q <= 1'b1;
      end else begin
        dac_q <= step_code;
        cnt_q <= cnt_q + CNT_W'(1);
        if (better) begin
          best_mag_q  <= cur_mag;
          best_code_q <= dac_q;
        end
      end
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!eval_evt && !start_evt) |=> $stable(dac_q)) else $error("code moved outside eval");
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_ITER - 1)) else $error("iteration count overrun");
  p_fail_budget_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_q) |-> ($past(cnt_q) == CNT_W'(MAX_ITER - 1))) else $error("early fail");

endmodule

// File: rtl/rx_offset_cal.sv
module rx_offset_cal #(
  parameter int SAMPLE_W   = 12,
  parameter int DAC_W      = 8,
  parameter int AVG_LOG2   = 6,
  parameter int SETTLE_CYC = 16,
  parameter int TOL        = 32,
  parameter int MAX_ITER   = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cal_start,
  input  logic                adc_valid,
  input  logic [SAMPLE_W-1:0] adc_data,
  output logic [DAC_W-1:0]    cal_dac,
  output logic                force_short,
  output logic                force_gain,
  output logic                busy,
  output logic                done,
  output logic                fail
);

  logic start_evt, eval_evt, acc_clear, acc_add, acc_last;
  logic hit_w, exhausted_w, busy_w;
  logic signed [SAMPLE_W-1:0] est_w;
  logic signed [DAC_W-1:0]    dac_w;

  rxcal_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .adc_valid(adc_valid),
    .acc_last(acc_last), .hit(hit_w), .exhausted(exhausted_w),
    .start_evt(start_evt), .eval_evt(eval_evt), .acc_clear(acc_clear),
    .acc_add(acc_add), .busy(busy_w), .done(done)
  );

  rxcal_avg #(.SAMPLE_W(SAMPLE_W), .AVG_LOG2(AVG_LOG2)) u_avg (
    .clk(clk), .rst_n(rst_n), .clear(acc_clear), .add(acc_add),
    .sample($signed(adc_data)), .est(est_w), .last(acc_last)
  );

  rxcal_servo #(.SAMPLE_W(SAMPLE_W), .DAC_W(DAC_W), .TOL(TOL), .MAX_ITER(MAX_ITER)) u_servo (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .eval_evt(eval_evt),
    .est(est_w), .dac(dac_w), .hit(hit_w), .exhausted(exhausted_w), .fail(fail)
  );

  assign cal_dac     = dac_w;
  assign busy        = busy_w;
  assign force_short = busy_w;
  assign force_gain  = busy_w;

  p_success_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fail) |-> $past(hit_w)) else $error("success outside window");
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_w && $past(!busy_w)) |-> $stable(cal_dac)) else $error("code drift while idle");

endmodule

// File: tb/rx_offset_cal_bench.sv
module rx_offset_cal_bench;
  localparam int MAXI = 40;
  localparam int MEAS = 81;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, cal_start = 1'b0, adc_valid = 1'b0;
  logic [11:0] adc_data = '0;
  logic [7:0]  cal_dac;
  logic force_short, force_gain, busy, done, fail;

  rx_offset_cal #(.MAX_ITER(MAXI)) u_rx_offset_cal (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .adc_valid(adc_valid),
    .adc_data(adc_data), .cal_dac(cal_dac), .force_short(force_short),
    .force_gain(force_gain), .busy(busy), .done(done), .fail(fail)
  );

  int tests = 0, fails = 0, cyc = 0;
  int offs = 0, kg = 4, dith = 0;
  bit gap = 1'b0, tog = 1'b0;
  int busy_cnt = 0, done_cnt = 0, done_busy_err = 0, force_err = 0;

  // Amplifier model: sample = offset + slope * code (+ alternating dither)
  always @(negedge clk) begin
    int v;
    tog = ~tog;
    v = offs + kg * int'($signed(cal_dac)) + (tog ? dith : -dith);
    if (v > 2047) v = 2047;
    if (v < -2048) v = -2048;
    adc_data  = 12'(v);
    adc_valid = gap ? tog : 1'b1;
  end

  always @(negedge clk) begin
    cyc++;
    if (busy) busy_cnt++;
    if (done) begin
      done_cnt++;
      if (busy) done_busy_err++;
    end
    if (force_short !== busy || force_gain !== busy) force_err++;
    if (cyc > 180000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    busy_cnt = 0; done_cnt = 0; done_busy_err = 0; force_err = 0;
  endtask

  task automatic wait_done();
    int guard = 0;
    while (done_cnt == 0 && guard < 30000) begin
      @(negedge clk); #1;
      guard++;
    end
    repeat (4) @(negedge clk);
    #1;
  endtask

  function automatic int steps_needed(input int o, input int k);
    int a = (o < 0) ? -o : o;
    return (a <= 32) ? 0 : (a - 32 + k - 1) / k;
  endfunction

  task automatic check_result(input int o, input int k, input bit exact_time);
    int n = steps_needed(o, k);
    int sgn = (o > 0) ? 1 : -1;
    int ecode, ebusy;
    bit efail;
    if (n <= MAXI - 1) begin
      ecode = -sgn * n; efail = 1'b0; ebusy = MEAS * (n + 1);
    end else begin
      ecode = -sgn * (MAXI - 1); efail = 1'b1; ebusy = MEAS * MAXI;
    end
    chk(int'($signed(cal_dac)) == ecode, efail ? "R8" : "R6", "final code",
        int'($signed(cal_dac)), ecode);
    chk(fail == efail, efail ? "R8" : "R5", "fail flag", int'(fail), int'(efail));
    if (exact_time) chk(busy_cnt == ebusy, "R7", "busy cycles", busy_cnt, ebusy);
    else chk(busy_cnt > ebusy, "R4", "gapped busy longer", busy_cnt, ebusy);
    chk(done_cnt == 1 && done_busy_err == 0, "R9", "done pulses", done_cnt, 1);
    chk(force_err == 0, "R3", "force mismatches", force_err, 0);
  endtask

  task automatic run(input int o, input int k, input int d, input bit g, input bit inject);
    @(posedge clk); #2;
    offs = o; kg = k; dith = d; gap = g;
    clear_mon();
    cal_start = 1'b1;
    @(posedge clk); #2;
    cal_start = 1'b0;
    if (inject) begin
      while (busy_cnt < 500) begin @(negedge clk); #1; end
      @(posedge clk); #2; cal_start = 1'b1;   // R10: request while busy
      @(posedge clk); #2; cal_start = 1'b0;
    end
    wait_done();
    check_result(o, k, !g);
  endtask

  initial begin
    int prev;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(busy && force_short && force_gain, "R1", "reset busy/force", int'(busy), 1);
    chk(cal_dac == 8'd0 && !done, "R1", "reset code", int'(cal_dac), 0);
    @(posedge clk); #2;
    clear_mon();
    rst_n = 1'b1;
    wait_done();
    check_result(0, 4, 1'b1);   // R1: automatic run after reset

    // Window edges and both signs (R5, R6)
    run(32, 4, 0, 1'b0, 1'b0);
    run(-32, 4, 0, 1'b0, 1'b0);
    run(33, 4, 0, 1'b0, 1'b0);
    run(-33, 4, 0, 1'b0, 1'b0);
    run(100, 4, 0, 1'b0, 1'b0);
    run(-300, 8, 0, 1'b0, 1'b0);
    // Dither that only the average removes (R4)
    run(20, 4, 50, 1'b0, 1'b0);
    // R10: request during a run ignored; final code -30
    run(150, 4, 0, 1'b0, 1'b1);
    // R2: restart from zero (continuing from -30 would stay at -30)
    run(100, 4, 0, 1'b0, 1'b0);
    // Gapped valids (R4)
    run(-100, 4, 0, 1'b1, 1'b0);
    // Budget exhausted (R8)
    run(500, 4, 0, 1'b0, 1'b0);
    run(-500, 4, 0, 1'b0, 1'b0);

    // R11: code held while idle under a large input change
    prev = int'($signed(cal_dac));
    @(posedge clk); #2;
    clear_mon();
    offs = 600; dith = 30;
    repeat (100) @(negedge clk);
    #1;
    chk(int'($signed(cal_dac)) == prev && busy_cnt == 0, "R11", "idle code",
        int'($signed(cal_dac)), prev);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule